// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit with Overflow Trap

This unit executes 32-bit tagged-integer arithmetic for a processor pipeline. One operation is presented per cycle with a valid strobe, an operation select (add or subtract) and two source operands. The two least significant bits of each operand hold a type tag. A well-formed tagged integer has both tag bits clear. The unit rejects any operand with a nonzero tag. It also rejects any operation whose signed 32-bit result overflows.

A rejected operation raises a trap pulse in the same cycle as the strobe. It produces no result and does not touch the condition codes. An accepted operation presents its result in the same cycle with a result-valid signal. The negative, zero, overflow and carry flags are registered on the following clock edge. Downstream logic that vectors the trap lives outside this block.

Top module: `tagarith_unit`

## Requirements
- R1: While synchronous active-high `rst` is high at a clock edge, all four flag outputs are cleared to 0 at that edge.
- R2: When `in_valid` is high, `op_sub` is 0 and no trap condition holds, `out_valid` is 1 in that cycle and `result` equals `src_a + src_b` modulo 2^32.
- R3: When `in_valid` is high, `op_sub` is 1 and no trap condition holds, `out_valid` is 1 and `result` equals `src_a - src_b` modulo 2^32.
- R4: If bit 0 or bit 1 of either operand is 1 while `in_valid` is high, `trap` is 1 and `out_valid` is 0 in that cycle, for both operations.
- R5: For an add, the operation traps when bit 31 of both operands is equal and bit 31 of the 32-bit sum differs from bit 31 of `src_a`.
- R6: For a subtract, the operation traps when bit 31 of the two operands differs and bit 31 of the 32-bit difference differs from bit 31 of `src_a`.
- R7: `trap` is high only in a cycle where `in_valid` is high, and `trap` and `out_valid` are never high together.
- R8: After a cycle with `out_valid` high, the flags become the following at the next edge. `flag_n` is result bit 31, `flag_z` is 1 when the result is zero and `flag_v` is 0. `flag_c` is the carry out of bit 31 for an add, or for a subtract it is the borrow, meaning 1 when `src_a < src_b` unsigned.
- R9: A cycle with `in_valid` low, or a trapping cycle, leaves all four flags unchanged at the next edge.
- R10: `result` is 0 in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flags |
| in_valid | input | 1 | Operation strobe |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| src_a | input | 32 | First operand (minuend for subtract) |
| src_b | input | 32 | Second operand (subtrahend for subtract) |
| out_valid | output | 1 | Result accepted this cycle |
| result | output | 32 | Sum or difference, zero when not accepted |
| trap | output | 1 | Tag-overflow trap pulse |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_c | output | 1 | Registered carry/borrow flag |

## Verification
The result and trap paths are combinational, so a wrong carry chain, sign comparison or tag mask shows on `result`, `trap` or `out_valid` in the same cycle as the strobe. The only internal state is the flag register. A bad commit enable or a wrong next-flag value shows on the flag pins one edge after the operation. A trap that leaks into the flags is exposed by placing a trapping operation between two accepted operations with different flag values.

// File: rtl/tagarith_pkg.sv
package tagarith_pkg;

    localparam int DEF_DATA_W = 32;
    localparam int DEF_TAG_W  = 2;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } arith_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } ccodes_t;

    localparam ccodes_t CC_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    // Signed overflow rule for a + b_eff (b_eff already inverted for subtract).
    function automatic logic sign_overflow(input logic a_msb, input logic b_eff_msb,
                                           input logic r_msb);
        return (a_msb == b_eff_msb) && (r_msb != a_msb);
    endfunction

endpackage

// File: rtl/tagarith_tag_check.sv
module tagarith_tag_check #(
    parameter int DATA_W = tagarith_pkg::DEF_DATA_W,
    parameter int TAG_W  = tagarith_pkg::DEF_TAG_W
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              tag_bad
);
    logic [TAG_W-1:0] bit_bad;

    for (genvar i = 0; i < TAG_W; i++) begin : g_tag
        assign bit_bad[i] = opnd_a[i] | opnd_b[i];
    end

    assign tag_bad = |bit_bad;
endmodule

// File: rtl/tagarith_addsub.sv
module tagarith_addsub
    import tagarith_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  arith_op_e         op,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] sum,
    output logic              carry,
    output logic              ovf
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;
    logic              is_sub;

    always_comb begin
        is_sub = (op == OP_SUB);
        b_eff  = is_sub ? ~opnd_b : opnd_b;
        wide   = {1'b0, opnd_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, is_sub};
        sum    = wide[MSB:0];
        // Carry out for add; borrow (inverted carry) for subtract.
        carry  = is_sub ? ~wide[DATA_W] : wide[DATA_W];
        ovf    = sign_overflow(opnd_a[MSB], b_eff[MSB], wide[MSB]);
    end
endmodule

// File: rtl/tagarith_flags.sv
module tagarith_flags
    import tagarith_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    commit,
    input  ccodes_t next_cc,
    output ccodes_t cc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cc <= CC_CLEAR;
        end else if (commit) begin
            cc <= next_cc;
        end
    end
endmodule

// File: rtl/tagarith_unit.sv
module tagarith_unit
    import tagarith_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int TAG_W  = DEF_TAG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              trap,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c
);
    localparam int MSB = DATA_W - 1;

    arith_op_e         op;
    logic              tag_bad;
    logic [DATA_W-1:0] raw_sum;
    logic              raw_carry;
    logic              raw_ovf;
    logic              commit;
    ccodes_t           next_cc;
    ccodes_t           cc_q;

    assign op = op_sub ? OP_SUB : OP_ADD;

    tagarith_tag_check #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_tag (
        .opnd_a  (src_a),
        .opnd_b  (src_b),
        .tag_bad (tag_bad)
    );

    tagarith_addsub #(.DATA_W(DATA_W)) u_alu (
        .op     (op),
        .opnd_a (src_a),
        .opnd_b (src_b),
        .sum    (raw_sum),
        .carry  (raw_carry),
        .ovf    (raw_ovf)
    );

    always_comb begin
        trap      = in_valid & (tag_bad | raw_ovf);
        commit    = in_valid & ~(tag_bad | raw_ovf);
        next_cc.n = raw_sum[MSB];
        next_cc.z = (raw_sum == '0);
        next_cc.v = raw_ovf;
        next_cc.c = raw_carry;
    end

    tagarith_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .next_cc (next_cc),
        .cc      (cc_q)
    );

    assign out_valid = commit;
    assign result    = commit ? raw_sum : '0;
    assign flag_n    = cc_q.n;
    assign flag_z    = cc_q.z;
    assign flag_v    = cc_q.v;
    assign flag_c    = cc_q.c;
endmodule

// File: rtl/tagarith_chk.sv
module tagarith_chk #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              op_sub,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic              trap,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_c
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] chk_sum;
    logic [DATA_W-1:0] chk_diff;
    logic [3:0]        flags;

    assign chk_sum  = src_a + src_b;
    assign chk_diff = src_a - src_b;
    assign flags    = {flag_n, flag_z, flag_v, flag_c};

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (flags == 4'b0000)); // R1
    AST_TAG_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ((src_a[TAG_W-1:0] | src_b[TAG_W-1:0]) != '0)) |-> (trap && !out_valid)); // R4
    AST_ADD_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_sub && (src_a[MSB] == src_b[MSB]) && (chk_sum[MSB] != src_a[MSB])) |-> trap); // R5
    AST_SUB_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sub && (src_a[MSB] != src_b[MSB]) && (chk_diff[MSB] != src_a[MSB])) |-> trap); // R6
    AST_TRAP_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) trap |-> in_valid); // R7
    AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(trap && out_valid)); // R7
    AST_Z_TRACKS: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> (flag_z == ($past(result) == '0))); // R8
    AST_N_TRACKS: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> (flag_n == $past(result[MSB]))); // R8
    AST_V_CLEAR: assert property (@(posedge clk) disable iff (rst) out_valid |=> !flag_v); // R8
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst) !out_valid |=> $stable(flags)); // R9
    AST_RESULT_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (result == '0)); // R10
endmodule

bind tagarith_unit tagarith_chk #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sub    (op_sub),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .result    (result),
    .trap      (trap),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c)
);

// File: tb/tb_tagarith_unit.sv
module tb_tagarith_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic        vld;
        logic [31:0] res;
        logic        trp;
        logic [3:0]  flg;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        op_sub = 1'b0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        out_valid, trap, flag_n, flag_z, flag_v, flag_c;
    logic [31:0] result;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 1'b0;
    item_t sb_q[$];
    logic [3:0] model_flg = 4'b0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    tagarith_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
        .trap(trap), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected outcome.
    task automatic drive(input bit v, input bit s, input logic [31:0] a,
                         input logic [31:0] b, input string req);
        item_t it;
        logic [32:0] w;
        logic tagb, ovf, carry;
        @(negedge clk);
        in_valid = v; op_sub = s; src_a = a; src_b = b;
        tagb  = ((a[1:0] | b[1:0]) != 2'b00);
        if (s) begin
            w     = {1'b0, a} - {1'b0, b};
            carry = (a < b);
            ovf   = (a[31] != b[31]) && (w[31] != a[31]);
        end else begin
            w     = {1'b0, a} + {1'b0, b};
            carry = w[32];
            ovf   = (a[31] == b[31]) && (w[31] != a[31]);
        end
        it.trp = v && (tagb || ovf);
        it.vld = v && !(tagb || ovf);
        it.res = it.vld ? w[31:0] : 32'h0;
        if (it.vld) model_flg = {w[31], (w[31:0] == 32'h0), 1'b0, carry};
        it.flg = model_flg;
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: outputs are combinational before the edge and flags settle after it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(out_valid == it.vld, it.req, "out_valid", {31'b0, out_valid}, {31'b0, it.vld});
                check(trap == it.trp, it.req, "trap", {31'b0, trap}, {31'b0, it.trp});
                check(result == it.res, it.req, "result", result, it.res);
                check({flag_n, flag_z, flag_v, flag_c} == it.flg, it.req, "flags",
                      {28'b0, flag_n, flag_z, flag_v, flag_c}, {28'b0, it.flg});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model_flg = 4'b0000;
        check({flag_n, flag_z, flag_v, flag_c} == 4'b0000, "R1", "flags after reset",
              {28'b0, flag_n, flag_z, flag_v, flag_c}, 32'h0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        do_reset();                                            // R1
        drive(1, 0, 32'h0000_0004, 32'h0000_0008, "R2");       // plain add
        drive(1, 0, 32'hFFFF_FFFC, 32'h0000_0004, "R2_R8");    // wrap to zero, carry
        drive(1, 1, 32'h0000_0008, 32'h0000_000C, "R3_R8");    // negative, borrow
        drive(1, 1, 32'h0000_0010, 32'h0000_0010, "R3_R8");    // zero difference
        drive(1, 1, 32'h8000_0000, 32'h8000_0000, "R3");       // same signs, no overflow
        drive(1, 0, 32'h0000_0101, 32'h0000_0004, "R4_R9");    // tag bit 0 in a
        drive(1, 1, 32'h0000_0020, 32'h0000_0002, "R4_R9");    // tag bit 1 in b
        drive(1, 0, 32'h7FFF_FFFC, 32'h0000_0004, "R5_R9");    // positive overflow
        drive(1, 0, 32'h8000_0000, 32'hFFFF_FFFC, "R5_R9");    // negative overflow
        drive(1, 0, 32'h7FFF_FFF8, 32'h0000_0004, "R5");       // just below limit
        drive(1, 1, 32'h8000_0000, 32'h0000_0004, "R6_R9");    // sub overflow low
        drive(1, 1, 32'h7FFF_FFFC, 32'hFFFF_FFFC, "R6_R9");    // sub overflow high
        drive(1, 1, 32'h8000_0004, 32'h0000_0004, "R6");       // sub at limit, no trap
        drive(0, 0, 32'h1234_5670, 32'h0000_0010, "R7_R10");   // idle with data
        drive(0, 1, 32'h0000_0003, 32'h0000_0001, "R7_R10");   // idle with bad tags
        drive(1, 0, 32'h0000_0004, 32'h0000_0004, "R2");       // back-to-back pair
        drive(1, 1, 32'h0000_0004, 32'h0000_0008, "R3");
        lf = 32'hACE1_2468;
        for (int i = 0; i < 40; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            drive(1, lf[5], lf & ((i % 4 == 0) ? 32'hFFFF_FFFF : 32'hFFFF_FFFC),
                  {lf[15:0], lf[31:16]} & 32'hFFFF_FFFC, "R2_R3_R8");
        end
        drive(1, 1, 32'h0000_0000, 32'h0000_0004, "R8");       // set N and C
        do_reset();                                            // R1 mid-run
        drive(0, 0, 32'h0, 32'h0, "R9");
        @(posedge clk);
        #2;
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule